// File: doc/BRIEF.md
# Bidirectional Conversion Sync Control

This block owns one bidirectional sync pin that sits beside a converter sequencer. A configuration bit sets the pin's direction. When the bit is clear the pin is an input. A rising edge seen on it is brought into the clock domain and becomes a single-cycle start request to the sequencer, which then runs either a conversion or a limit comparison. When the bit is set the pin is an output. The block drives it high for as long as a sequencer operation is in progress, so other devices can follow the activity.

The sequencer is modelled through a simple handshake. The block sends it a start pulse. The sequencer reports back with a busy level, which rises when an operation begins, and with a done pulse in the cycle that ends the operation. The pin is split into a data input, a data output and an output-enable, for a pad cell outside the block.

Top module: `sync_pin_ctrl`

## Requirements
- R1: After reset, pin_oe, pin_o and seq_start_o are all 0, and the direction register holds input mode.
- R2: pin_oe is the direction bit registered once: after the clock edge that samples dir_out_i, pin_oe equals that value (1 = output, 0 = input).
- R3: In input mode, if pin_i is sampled 0 at clock edge k-1 and 1 at edge k, seq_start_o is 1 during the cycle after edge k+2. That is two synchroniser flops plus one output register.
- R4: seq_start_o is never high for two consecutive cycles, however long pin_i stays high.
- R5: A rising edge is ignored when the direction register is 1 in the cycle where the synchronised edge is detected. No start pulse results.
- R6: A rising edge is ignored when seq_busy_i is 1 at the edge that would register the start pulse. It is not held back, and no start follows once busy falls.
- R7: In output mode, the clock edge that samples seq_busy_i going from 0 to 1 drives pin_o to 1 from the next cycle, unless seq_done_i is sampled 1 at that same edge.
- R8: In output mode, pin_o stays 1 until the edge that samples seq_done_i = 1. After that edge pin_o is 0.
- R9: pin_o is 0 whenever pin_oe is 0, so in input mode the pin output is never driven high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_out_i | input | 1 | Direction configuration bit, 1 = output, 0 = input |
| pin_i | input | 1 | Level read from the sync pin, asynchronous |
| pin_o | output | 1 | Level driven onto the sync pin in output mode |
| pin_oe | output | 1 | Output-enable for the sync pin pad |
| seq_busy_i | input | 1 | Sequencer reports an operation in progress |
| seq_done_i | input | 1 | Sequencer pulse marking the end of an operation |
| seq_start_o | output | 1 | One-cycle start request to the sequencer |

## Verification
The assertions take the sequencer handshake as it is on the pins. They assume nothing about how busy and done relate, so a done pulse without busy, or busy held across several done pulses, must still leave the properties true. The stimulus therefore draws pin_i, seq_busy_i, seq_done_i and the direction bit freely and independently from a seeded generator. Directed stretches run between the random ones to place long pin highs, edges under busy, and mode switches exactly where the requirements call for them.

// File: rtl/sync_pin_pkg.sv
package sync_pin_pkg;

  // Edge event: level is high now and was low one cycle before.
  function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Activity tracker next state: a begin event sets it, a done pulse clears it with priority.
  function automatic logic next_active(input logic begin_ev, input logic cur, input logic done);
    return (begin_ev | cur) & ~done;
  endfunction

  // Start is allowed only in input mode with an idle sequencer.
  function automatic logic start_ok(input logic edge_ev, input logic is_out, input logic busy);
    return edge_ev & ~is_out & ~busy;
  endfunction

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spc_trigger.sv
module spc_trigger
  import sync_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic out_mode_i,
  input  logic busy_i,
  output logic rise_o,
  output logic start_o
);
  logic prev_q;
  logic start_q;

  assign rise_o = rise_of(level_i, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      prev_q  <= level_i;
      start_q <= start_ok(rise_o, out_mode_i, busy_i);
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/spc_activity.sv
module spc_activity
  import sync_pin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic done_i,
  output logic busy_rise_o,
  output logic active_o
);
  logic busy_prev_q;
  logic act_q;

  assign busy_rise_o = rise_of(busy_i, busy_prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_prev_q <= 1'b0;
      act_q       <= 1'b0;
    end else begin
      busy_prev_q <= busy_i;
      act_q       <= next_active(busy_rise_o, act_q, done_i);
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sync_pin_ctrl.sv
module sync_pin_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_out_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe,
  input  logic seq_busy_i,
  input  logic seq_done_i,
  output logic seq_start_o
);
  logic dir_q;
  logic pin_sync_w;
  logic rise_w;
  logic busy_rise_w;
  logic active_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_out_i;
  end

  spc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync_w)
  );

  spc_trigger u_trig (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_i    (pin_sync_w),
    .out_mode_i (dir_q),
    .busy_i     (seq_busy_i),
    .rise_o     (rise_w),
    .start_o    (seq_start_o)
  );

  spc_activity u_act (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (seq_busy_i),
    .done_i      (seq_done_i),
    .busy_rise_o (busy_rise_w),
    .active_o    (active_w)
  );

  assign pin_oe = dir_q;
  assign pin_o  = dir_q & active_w;
endmodule

// File: rtl/sync_pin_ctrl_chk.sv
module sync_pin_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dir_out_i,
  input logic seq_busy_i,
  input logic seq_done_i,
  input logic pin_o,
  input logic pin_oe,
  input logic seq_start_o,
  input logic dir_q,
  input logic rise_w,
  input logic busy_rise_w
);
  p_oe_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pin_oe == $past(dir_out_i)));

  p_start_from_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_o |-> $past(rise_w));

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_o |=> !seq_start_o);

  p_no_start_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_o |-> !$past(dir_q));

  p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_o |-> !$past(seq_busy_i));

  p_pin_on_begin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_rise_w && !seq_done_i && dir_out_i) |=> pin_o);

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_o && !seq_done_i && dir_out_i) |=> pin_o);

  p_pin_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done_i |=> !pin_o);

  p_quiet_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_o);
endmodule

bind sync_pin_ctrl sync_pin_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dir_out_i   (dir_out_i),
  .seq_busy_i  (seq_busy_i),
  .seq_done_i  (seq_done_i),
  .pin_o       (pin_o),
  .pin_oe      (pin_oe),
  .seq_start_o (seq_start_o),
  .dir_q       (dir_q),
  .rise_w      (rise_w),
  .busy_rise_w (busy_rise_w)
);

// File: tb/sync_pin_ctrl_tb.sv
`timescale 1ns/1ps
module sync_pin_ctrl_tb;
  localparam real HALF = 2.5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_out_i = 1'b0, pin_i = 1'b0, seq_busy_i = 1'b0, seq_done_i = 1'b0;
  logic pin_o, pin_oe, seq_start_o;

  int n_cmp = 0, n_bad = 0;

  // Reference model state: input history from earlier clock edges.
  logic h_p1 = 0, h_p2 = 0, h_p3 = 0, h_d1 = 0, h_b1 = 0, h_act = 0;
  logic e_start = 0, e_pin = 0, e_oe = 0;
  string t_start = "R1", t_pin = "R1", t_oe = "R1";

  always #(HALF) clk = ~clk;

  sync_pin_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .dir_out_i(dir_out_i), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .seq_busy_i(seq_busy_i),
    .seq_done_i(seq_done_i), .seq_start_o(seq_start_o)
  );

  // Pin high now after low a cycle earlier, counted from the edge that sampled it.
  function automatic logic want_start(input logic lvl_k2, input logic lvl_k3,
                                      input logic dir_k1, input logic busy_k);
    if (dir_k1 || busy_k) return 1'b0;
    return (lvl_k2 == 1'b1) && (lvl_k3 == 1'b0);
  endfunction

  function automatic logic want_active(input logic busy_k, input logic busy_k1,
                                       input logic was, input logic done_k);
    if (done_k) return 1'b0;
    if (busy_k && !busy_k1) return 1'b1;
    return was;
  endfunction

  task automatic cmp(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model step at each rising edge, using the inputs that edge samples.
  task automatic model_edge();
    if (!rst_n) begin
      {h_p1, h_p2, h_p3, h_d1, h_b1, h_act} = '0;
      {e_start, e_pin, e_oe} = '0;
    end else begin
      e_start = want_start(h_p2, h_p3, h_d1, seq_busy_i);
      h_act   = want_active(seq_busy_i, h_b1, h_act, seq_done_i);
      e_pin   = dir_out_i && h_act;
      e_oe    = dir_out_i;
      h_p3 = h_p2; h_p2 = h_p1; h_p1 = pin_i;
      h_d1 = dir_out_i; h_b1 = seq_busy_i;
    end
  endtask

  task automatic cyc(input logic p, input logic d, input logic b, input logic dn);
    @(negedge clk);
    cmp(t_start, seq_start_o, e_start);
    cmp(t_pin, pin_o, e_pin);
    cmp(t_oe, pin_oe, e_oe);
    pin_i = p; dir_out_i = d; seq_busy_i = b; seq_done_i = dn;
    @(posedge clk);
    model_edge();
  endtask

  task automatic tags(input string s, input string p, input string o);
    t_start = s; t_pin = p; t_oe = o;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, inputs busy with dir set during reset
    dir_out_i = 1'b1;
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    cmp("R1", pin_oe, 1'b0);
    cmp("R1", pin_o, 1'b0);
    cmp("R1", seq_start_o, 1'b0);
    rst_n = 1'b1;
    dir_out_i = 1'b0;
    @(posedge clk);
    model_edge();

    // R3 and R4: input mode, pin held high for many cycles
    tags("R4", "R9", "R2");
    repeat (4) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    repeat (10) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    tags("R3", "R9", "R2");
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (5) cyc(1'b0, 1'b0, 1'b0, 1'b0);

    // R6: edge during busy, then busy drops: no late start
    tags("R6", "R9", "R2");
    repeat (6) cyc(1'b1, 1'b0, 1'b1, 1'b0);
    repeat (8) cyc(1'b1, 1'b0, 1'b0, 1'b0);
    repeat (4) cyc(1'b0, 1'b0, 1'b0, 1'b0);

    // R5: output mode, pin toggles give no start
    tags("R5", "R9", "R2");
    repeat (4) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) cyc(i[1], 1'b1, 1'b0, 1'b0);
    repeat (4) cyc(1'b0, 1'b1, 1'b0, 1'b0);

    // R7 and R8: busy begins, held, done ends it
    tags("R5", "R7", "R2");
    repeat (2) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    tags("R5", "R8", "R2");
    repeat (6) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1);
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0);
    // begin and done in the same edge: stays low
    tags("R5", "R7", "R2");
    cyc(1'b0, 1'b1, 1'b1, 1'b1);
    repeat (3) cyc(1'b0, 1'b1, 1'b0, 1'b0);

    // R9: input mode, sequencer activity never drives the pin
    tags("R3", "R9", "R2");
    repeat (3) cyc(1'b0, 1'b0, 1'b1, 1'b0);
    repeat (3) cyc(1'b0, 1'b0, 1'b1, 1'b1);
    repeat (3) cyc(1'b0, 1'b0, 1'b0, 1'b0);

    // Random phase: all inputs drawn independently
    tags("R3", "R7", "R2");
    for (int i = 0; i < 4000; i++) begin
      logic rp, rd, rb, rdn;
      rp  = ($urandom % 4) != 0 ? pin_i : ~pin_i;
      rd  = ($urandom % 64) == 0 ? ~dir_out_i : dir_out_i;
      rb  = ($urandom % 6) == 0 ? ~seq_busy_i : seq_busy_i;
      rdn = ($urandom % 10) == 0;
      cyc(rp, rd, rb, rdn);
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule